// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns three distinct fault sources into one clean system reset of a guaranteed minimum width. The sources are a power-fail flag from an external supply comparator (active high, asynchronous), a mechanical pushbutton (active low, bouncing) and a one-cycle expiry request from a watchdog timer. The block drives the reset in both polarities so that loads of either polarity can be fed from the same source.

A pushbutton press is synchronised and then accepted only once its level has been steady for a debounce interval. While any level cause (power fail or a debounced press) is present, reset is held. When the last cause goes away, reset is stretched for a minimum time. The stretch always restarts from the removal of the most recent cause, so a cause that arrives during a stretch extends it. The block's own asynchronous init also asserts reset and then gives one full stretch. Durations are set in milliseconds and converted to cycles through the clock frequency parameter. With the defaults (250 ms at 50 MHz) the stretch is N = (CLK_HZ/1000)*STRETCH_MS cycles and the debounce is D = (CLK_HZ/1000)*DEB_MS cycles.

Top module: `rstPulseGen`

## Requirements
- R1: While `rstAsyncN` is low, `rstOut` is 1. After `rstAsyncN` rises, and with no cause present, `rstOut` falls between N and N+4 rising clock edges later.
- R2: While `pwrFail` is 1, `rstOut` becomes 1 within 4 clock edges and stays 1.
- R3: After `pwrFail` returns to 0 with no other cause present, `rstOut` stays 1 and falls between N and N+4 rising edges after the change. The stretch counter never wraps.
- R4: A low level on `btnN` is accepted as a press only after it has been steady for D consecutive synchronised cycles. A low pulse of D/2 cycles leaves `rstOut` at 0. A press held longer than D sets `rstOut` to 1.
- R5: After a held press is released (`btnN` back to 1), `rstOut` falls between N+D and N+D+4 rising edges after the release.
- R6: A one-cycle `wdExpire` pulse sets `rstOut` to 1 at the edge that samples it. `rstOut` then falls between N and N+4 edges after the pulse ends.
- R7: A cause that arrives during a stretch holds reset and restarts the stretch from its own removal. The release then falls between N and N+4 edges after that removal, regardless of how much of the earlier stretch had elapsed.
- R8: `rstOutN` is always the complement of `rstOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstAsyncN | input | 1 | Asynchronous power-on init, active low |
| pwrFail | input | 1 | Supply out-of-tolerance flag, active high, asynchronous |
| btnN | input | 1 | Pushbutton, active low, asynchronous and bouncing |
| wdExpire | input | 1 | Watchdog expiry request, one synchronous cycle |
| rstOut | output | 1 | System reset, active high |
| rstOutN | output | 1 | System reset, active low |

## Verification
Two functions can coincide in one cycle: the removal of a level cause and a fresh watchdog request. Another case is a request that lands while a stretch is already counting. The bench drives `pwrFail` low and `wdExpire` high at the same clock. It also fires a watchdog pulse halfway through a stretch and then raises the power-fail flag. In each case the scoreboard expects exactly one release, timed from the latest removal, and flags any extra release or one that comes early.

// File: rtl/rstSupPkg.sv
package rstSupPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLD    = 2'd1,
    ST_STRETCH = 2'd2
  } supState_t;

  typedef struct packed {
    logic loadStretch;
    logic decStretch;
  } ctlStrobe_t;

endpackage

// File: rtl/rstSupSync.sv
module rstSupSync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstAsyncN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) chain[0] <= '0;
    else            chain[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstAsyncN) begin
      if (!rstAsyncN) chain[s] <= '0;
      else            chain[s] <= chain[s-1];
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/rstSupDatapath.sv
module rstSupDatapath
  import rstSupPkg::*;
#(
  parameter int unsigned STRETCH_CYC = 12_500_000,
  parameter int unsigned DEB_CYC     = 500_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstAsyncN,
  input  logic       pwrFail,
  input  logic       btnN,
  input  ctlStrobe_t strobe,
  output logic       pfLevel,
  output logic       btnLevel,
  output logic       cntZero
);

  localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1);
  localparam int unsigned DEB_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] STRETCH_LOAD = CNT_W'(STRETCH_CYC - 1);
  localparam logic [DEB_W-1:0] DEB_LAST     = DEB_W'(DEB_CYC - 1);

  logic [1:0] syncOut;
  logic       btnRaw;
  logic [DEB_W-1:0] debCnt;
  logic [CNT_W-1:0] stretchCnt;

  rstSupSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstAsyncN(rstAsyncN),
    .dIn      ({pwrFail, ~btnN}),
    .dOut     (syncOut)
  );

  assign pfLevel = syncOut[1];
  assign btnRaw  = syncOut[0];

  // Debounce: flip the accepted level after DEB_CYC steady differing cycles
  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      debCnt   <= '0;
      btnLevel <= 1'b0;
    end else if (btnRaw == btnLevel) begin
      debCnt <= '0;
    end else if (debCnt == DEB_LAST) begin
      debCnt   <= '0;
      btnLevel <= btnRaw;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  // Stretch counter, starts loaded so power-on gives one full stretch
  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN)              stretchCnt <= STRETCH_LOAD;
    else if (strobe.loadStretch) stretchCnt <= STRETCH_LOAD;
    else if (strobe.decStretch)  stretchCnt <= stretchCnt - 1'b1;
  end

  assign cntZero = (stretchCnt == '0);

  // R3: control never asks for a decrement of an exhausted counter
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstAsyncN)
    strobe.decStretch |-> !cntZero);

  // R4: accepted level only moves after a full steady interval
  p_deb_flip_r4: assert property (@(posedge clk) disable iff (!rstAsyncN)
    !$stable(btnLevel) |-> ($past(debCnt) == DEB_LAST));

  // R4: agreement between raw and accepted level freezes the accepted level
  p_deb_hold_r4: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (btnRaw == btnLevel) |=> $stable(btnLevel));

endmodule

// File: rtl/rstSupCtrl.sv
module rstSupCtrl
  import rstSupPkg::*;
(
  input  logic       clk,
  input  logic       rstAsyncN,
  input  logic       pfLevel,
  input  logic       btnLevel,
  input  logic       wdExpire,
  input  logic       cntZero,
  output ctlStrobe_t strobe,
  output logic       rstQ
);

  supState_t state, stateNxt;
  logic      cause;

  assign cause = pfLevel | btnLevel | wdExpire;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cause) stateNxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (!cause) begin
          stateNxt           = ST_STRETCH;
          strobe.loadStretch = 1'b1;
        end
      end
      ST_STRETCH: begin
        if (cause)        stateNxt = ST_HOLD;
        else if (cntZero) stateNxt = ST_IDLE;
        else              strobe.decStretch = 1'b1;
      end
      default: stateNxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      state <= ST_STRETCH;
      rstQ  <= 1'b1;
    end else begin
      state <= stateNxt;
      rstQ  <= (stateNxt != ST_IDLE);
    end
  end

  // R2: a sampled supply fault keeps reset on
  p_pf_forces_r2: assert property (@(posedge clk) disable iff (!rstAsyncN)
    pfLevel |=> rstQ);

  // R4: an accepted press keeps reset on
  p_btn_forces_r4: assert property (@(posedge clk) disable iff (!rstAsyncN)
    btnLevel |=> rstQ);

  // R6: a watchdog request asserts reset at the sampling edge
  p_wd_forces_r6: assert property (@(posedge clk) disable iff (!rstAsyncN)
    wdExpire |=> rstQ);

  // R3: release only once the stretch is exhausted and no cause is present
  p_release_gated_r3: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $fell(rstQ) |-> $past(cntZero && !cause));

  // R7: a cause during a stretch returns the controller to holding
  p_retrigger_r7: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (state == ST_STRETCH && cause) |=> (state == ST_HOLD && rstQ));

endmodule

// File: rtl/rstPulseGen.sv
module rstPulseGen
  import rstSupPkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned STRETCH_MS  = 250,
  parameter int unsigned DEB_MS      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstAsyncN,
  input  logic pwrFail,
  input  logic btnN,
  input  logic wdExpire,
  output logic rstOut,
  output logic rstOutN
);

  localparam int unsigned CYC_PER_MS  = CLK_HZ / 1000;
  localparam int unsigned STRETCH_CYC = CYC_PER_MS * STRETCH_MS;
  localparam int unsigned DEB_CYC     = CYC_PER_MS * DEB_MS;

  ctlStrobe_t strobe;
  logic       pfLevel, btnLevel, cntZero, rstQ;

  rstSupDatapath #(
    .STRETCH_CYC(STRETCH_CYC),
    .DEB_CYC    (DEB_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstAsyncN(rstAsyncN),
    .pwrFail  (pwrFail),
    .btnN     (btnN),
    .strobe   (strobe),
    .pfLevel  (pfLevel),
    .btnLevel (btnLevel),
    .cntZero  (cntZero)
  );

  rstSupCtrl u_ctl (
    .clk      (clk),
    .rstAsyncN(rstAsyncN),
    .pfLevel  (pfLevel),
    .btnLevel (btnLevel),
    .wdExpire (wdExpire),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .rstQ     (rstQ)
  );

  assign rstOut  = rstQ;
  assign rstOutN = ~rstQ;

endmodule

// File: tb/sim_rstPulseGen.sv
module sim_rstPulseGen;

  localparam int CLK_HZ = 20_000;
  localparam int N      = (CLK_HZ / 1000) * 250;
  localparam int D      = (CLK_HZ / 1000) * 10;
  localparam int SLACK  = 4;

  typedef struct {
    int    start;
    int    lo;
    int    hi;
    string tag;
  } expRel_t;

  logic clk = 1'b0;
  logic rstAsyncN = 1'b0;
  logic pwrFail = 1'b0;
  logic btnN = 1'b1;
  logic wdExpire = 1'b0;
  logic rstOut, rstOutN;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int complBad = 0;
  bit prevRst = 1'b1;
  expRel_t expQ[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  rstPulseGen #(.CLK_HZ(CLK_HZ)) u0 (
    .clk      (clk),
    .rstAsyncN(rstAsyncN),
    .pwrFail  (pwrFail),
    .btnN     (btnN),
    .wdExpire (wdExpire),
    .rstOut   (rstOut),
    .rstOutN  (rstOutN)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expectRelease(int lo, string tag);
    expRel_t e;
    e.start = cyc;
    e.lo    = lo;
    e.hi    = lo + SLACK;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  task automatic waitDrained();
    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // Monitor: pop one expectation per release and judge its timing
  always @(negedge clk) begin
    if (rstOutN !== ~rstOut) complBad++;
    if (rstAsyncN && prevRst && !rstOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected release", cyc, -1);
      end else begin
        expRel_t e;
        int dly;
        e   = expQ.pop_front();
        dly = cyc - e.start;
        check(dly >= e.lo && dly <= e.hi, e.tag, "release delay low bound", dly, e.lo);
      end
    end
    prevRst = rstOut;
  end

  // Watchdog
  initial begin
    repeat (120_000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset during init and after it
    repeat (5) @(negedge clk);
    check(rstOut === 1'b1 && rstOutN === 1'b0, "R1", "rstOut during init", rstOut, 1);
    @(negedge clk);
    rstAsyncN = 1'b1;
    expectRelease(N, "R1");
    waitDrained();
    check(rstOut === 1'b0, "R1", "rstOut idle after power-on stretch", rstOut, 0);

    // R2 / R3: supply fault
    @(negedge clk);
    pwrFail = 1'b1;
    repeat (4) @(negedge clk);
    check(rstOut === 1'b1, "R2", "rstOut soon after pwrFail", rstOut, 1);
    repeat (300) @(negedge clk);
    check(rstOut === 1'b1, "R2", "rstOut while pwrFail held", rstOut, 1);
    pwrFail = 1'b0;
    expectRelease(N, "R3");
    waitDrained();

    // R4: short glitch ignored
    @(negedge clk);
    btnN = 1'b0;
    repeat (D / 2) @(negedge clk);
    btnN = 1'b1;
    repeat (D + 20) @(negedge clk);
    check(rstOut === 1'b0, "R4", "rstOut after short glitch", rstOut, 0);

    // R4 / R5: held press
    btnN = 1'b0;
    repeat (D + 10) @(negedge clk);
    check(rstOut === 1'b1, "R4", "rstOut after debounced press", rstOut, 1);
    repeat (2 * D) @(negedge clk);
    btnN = 1'b1;
    expectRelease(N + D, "R5");
    waitDrained();

    // R6: watchdog pulse
    wdExpire = 1'b1;
    @(negedge clk);
    wdExpire = 1'b0;
    check(rstOut === 1'b1, "R6", "rstOut after watchdog pulse", rstOut, 1);
    expectRelease(N, "R6");
    waitDrained();

    // R7: supply fault arriving mid-stretch restarts it
    wdExpire = 1'b1;
    @(negedge clk);
    wdExpire = 1'b0;
    repeat (N / 2) @(negedge clk);
    pwrFail = 1'b1;
    repeat (50) @(negedge clk);
    check(rstOut === 1'b1, "R7", "rstOut while retriggered", rstOut, 1);
    pwrFail = 1'b0;
    expectRelease(N, "R7");
    waitDrained();

    // R7: fault removal and watchdog request in the same cycle
    pwrFail = 1'b1;
    repeat (20) @(negedge clk);
    pwrFail  = 1'b0;
    wdExpire = 1'b1;
    expectRelease(N, "R7");
    @(negedge clk);
    wdExpire = 1'b0;
    waitDrained();

    // R8: complement held throughout
    check(complBad == 0, "R8", "complement mismatches", complBad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule